// File: doc/BRIEF.md
# Registered Programmable-Array Output Cell

This block is a single output cell of a programmable-array logic device together with the group of product terms that feeds it. Every term is a programmable AND over the device inputs and a feedback bit; each input can enter in true form, in inverted form, or not at all. Eight terms are dedicated to the cell and are combined by a fixed OR. Three more terms serve as controls: one enables the output driver, one presets the storage flop on the next clock edge, and one clears the flop at once.

Two static configuration bits choose how the sum reaches the pad. In combinational mode the OR result drives the pad directly. In registered mode it passes through a D flip-flop on the clock that all cells share. A polarity bit can invert the pad value in either mode. The value fed back to the array is the flop output in registered mode, and the level seen on the pad in combinational mode. The bidirectional pad is split into an output, an output enable and an input, so the surrounding pad ring completes the three-state pin. The term masks and the two mode bits sit in registers that load when the write strobe is high.

Top module: `pal_macrocell`

## Requirements
- R1: The array input vector x has bit j = in_i[j] for j < N_IN, and bit N_IN is the feedback bit. Term k uses the mask bits cfg_true_i[k*(N_IN+1) +: N_IN+1] and cfg_comp_i at the same position. The term is 1 exactly when every x bit whose true-mask bit is set is 1 and every x bit whose complement-mask bit is set is 0. Setting both mask bits for one input forces the term to 0.
- R2: Terms 0 to 7 are ORed. In combinational mode (cfg_reg_i = 0) pad_o equals that sum within the same cycle, with no clock edge.
- R3: In registered mode (cfg_reg_i = 1) pad_o changes only at a rising clk edge, where the flop captures the sum. Before the edge, pad_o keeps its old value.
- R4: When term 9 (preset) is 1 at a rising edge and clear is 0, the flop becomes 1 whatever the sum.
- R5: While term 10 (clear) is 1, the flop is 0 at once without any clock edge. Clear wins over preset.
- R6: With cfg_pol_i = 1, pad_o is the inverse of the combinational or registered value.
- R7: pad_oe_o equals term 8 at all times.
- R8: The feedback bit is the flop output in registered mode and pad_i in combinational mode.
- R9: Configuration inputs are captured at a rising edge while cfg_we is 1 and take effect after that edge. Changes while cfg_we is 0 are ignored.
- R10: While rst_n is low the flop is 0 and every mask bit is 1, so all terms are 0. The cell is then in combinational mode with normal polarity, and pad_o and pad_oe_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cells |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_i | input | N_IN | Array inputs from device pins |
| pad_i | input | 1 | Level seen on the pad |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_true_i | input | (N_SUM+3)*(N_IN+1) | True-form connection mask per term |
| cfg_comp_i | input | (N_SUM+3)*(N_IN+1) | Complement-form connection mask per term |
| cfg_reg_i | input | 1 | 1 = registered mode, 0 = combinational |
| cfg_pol_i | input | 1 | 1 = inverted pad output |
| pad_o | output | 1 | Pad output value |
| pad_oe_o | output | 1 | Pad driver enable |

## Verification
The combinational results are due in the same cycle as their stimulus: the pad value in combinational mode, the output enable, the asynchronous clear and the combinational feedback. The bench drives inputs on the falling edge and samples 5 ns later, before any rising edge. The registered value, preset and configuration writes are due one rising edge later. For these the bench samples once before the edge, to confirm nothing has moved yet, and again after the following falling edge. The feedback toggle in registered mode is checked as the inverse of the previous cycle's pad value across each edge.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic {
    MODE_COMB = 1'b0,
    MODE_REG  = 1'b1
  } cell_mode_e;

  typedef struct packed {
    cell_mode_e mode;
    logic       invert;
  } cell_cfg_t;

  // polarity stage at the pad
  function automatic logic apply_polarity(input logic v, input logic invert);
    return invert ? ~v : v;
  endfunction

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
  parameter int MASK_W = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MASK_W-1:0] true_d,
  input  logic [MASK_W-1:0] comp_d,
  input  pal_pkg::cell_cfg_t cell_d,
  output logic [MASK_W-1:0] true_q,
  output logic [MASK_W-1:0] comp_q,
  output pal_pkg::cell_cfg_t cell_q
);
  import pal_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      true_q <= '1;
      comp_q <= '1;
      cell_q <= '{mode: MODE_COMB, invert: 1'b0};
    end else if (we) begin
      true_q <= true_d;
      comp_q <= comp_d;
      cell_q <= cell_d;
    end
  end

endmodule

// File: rtl/pal_and_array.sv
module pal_and_array #(
  parameter int IN_W    = 9,
  parameter int N_TERMS = 11,
  localparam int MASK_W = IN_W * N_TERMS
) (
  input  logic [IN_W-1:0]    x,
  input  logic [MASK_W-1:0]  true_mask,
  input  logic [MASK_W-1:0]  comp_mask,
  output logic [N_TERMS-1:0] terms
);

  // a connected true input must be 1, a connected complement input must be 0
  function automatic logic eval_term(input logic [IN_W-1:0] v,
                                     input logic [IN_W-1:0] t,
                                     input logic [IN_W-1:0] c);
    return &((~t | v) & (~c | ~v));
  endfunction

  for (genvar k = 0; k < N_TERMS; k++) begin : g_term
    assign terms[k] = eval_term(x, true_mask[k*IN_W +: IN_W],
                                comp_mask[k*IN_W +: IN_W]);
  end

endmodule

// File: rtl/pal_or_sum.sv
module pal_or_sum #(
  parameter int N_SUM = 8
) (
  input  logic [N_SUM-1:0] terms,
  output logic             sum
);
  logic [N_SUM:0] chain;

  assign chain[0] = 1'b0;
  for (genvar k = 0; k < N_SUM; k++) begin : g_or
    assign chain[k+1] = chain[k] | terms[k];
  end
  assign sum = chain[N_SUM];

endmodule

// File: rtl/pal_out_flop.sv
module pal_out_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic aclr,
  input  logic spre,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n or posedge aclr) begin
    if (!rst_n)    q <= 1'b0;
    else if (aclr) q <= 1'b0;
    else if (spre) q <= 1'b1;
    else           q <= d;
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_IN  = 8,
  parameter int N_SUM = 8,
  localparam int IN_W    = N_IN + 1,
  localparam int N_TERMS = N_SUM + 3,
  localparam int MASK_W  = IN_W * N_TERMS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_i,
  input  logic              pad_i,
  input  logic              cfg_we,
  input  logic [MASK_W-1:0] cfg_true_i,
  input  logic [MASK_W-1:0] cfg_comp_i,
  input  logic              cfg_reg_i,
  input  logic              cfg_pol_i,
  output logic              pad_o,
  output logic              pad_oe_o
);
  import pal_pkg::*;

  localparam int T_OE  = N_SUM;
  localparam int T_PRE = N_SUM + 1;
  localparam int T_CLR = N_SUM + 2;

  logic [MASK_W-1:0]  true_q, comp_q;
  cell_cfg_t          cell_d, cell_q;
  logic [N_TERMS-1:0] terms;
  logic [IN_W-1:0]    arr_in;

  // named internal events
  logic sum_w, oe_w, preset_w, clear_w, q_w, fb_w, reg_mode_w;

  assign cell_d = '{mode: cell_mode_e'(cfg_reg_i), invert: cfg_pol_i};

  pal_cfg_store #(.MASK_W(MASK_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .true_d (cfg_true_i),
    .comp_d (cfg_comp_i),
    .cell_d (cell_d),
    .true_q (true_q),
    .comp_q (comp_q),
    .cell_q (cell_q)
  );

  assign reg_mode_w = (cell_q.mode == MODE_REG);
  assign fb_w       = reg_mode_w ? q_w : pad_i;
  assign arr_in     = {fb_w, in_i};

  pal_and_array #(.IN_W(IN_W), .N_TERMS(N_TERMS)) u_and (
    .x         (arr_in),
    .true_mask (true_q),
    .comp_mask (comp_q),
    .terms     (terms)
  );

  pal_or_sum #(.N_SUM(N_SUM)) u_or (
    .terms (terms[N_SUM-1:0]),
    .sum   (sum_w)
  );

  assign oe_w     = terms[T_OE];
  assign preset_w = terms[T_PRE];
  assign clear_w  = terms[T_CLR];

  pal_out_flop u_ff (
    .clk   (clk),
    .rst_n (rst_n),
    .aclr  (clear_w),
    .spre  (preset_w),
    .d     (sum_w),
    .q     (q_w)
  );

  assign pad_o    = apply_polarity(reg_mode_w ? q_w : sum_w, cell_q.invert);
  assign pad_oe_o = oe_w;

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk (
  input logic clk,
  input logic rst_n,
  input logic sum_w,
  input logic preset_w,
  input logic clear_w,
  input logic q_w,
  input logic reg_mode_w,
  input logic pad_o,
  input logic invert_w
);

  // R5: clear active means the flop is already low
  a_r5_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |-> !q_w);

  // R4: preset without clear sets the flop on the edge
  a_r4_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_w && !clear_w) |=> (q_w || clear_w));

  // R3: plain capture of the sum
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode_w && !preset_w && !clear_w) |=> (q_w == $past(sum_w) || clear_w));

  // R2: combinational mode passes the OR sum to the pad
  a_r2_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_mode_w |-> (pad_o == (sum_w ^ invert_w)));

endmodule

bind pal_macrocell pal_macrocell_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sum_w      (sum_w),
  .preset_w   (preset_w),
  .clear_w    (clear_w),
  .q_w        (q_w),
  .reg_mode_w (reg_mode_w),
  .pad_o      (pad_o),
  .invert_w   (cell_q.invert)
);

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;
  localparam int N_IN = 8;
  localparam int N_SUM = 8;
  localparam int IN_W = N_IN + 1;
  localparam int N_TERMS = N_SUM + 3;
  localparam int MASK_W = IN_W * N_TERMS;
  localparam int FB = N_IN;

  // {in, expected pad_o, expected pad_oe} for config A
  localparam logic [9:0] VEC [0:7] = '{
    {8'h03, 1'b1, 1'b0}, {8'h08, 1'b1, 1'b0}, {8'h0C, 1'b0, 1'b0},
    {8'h80, 1'b0, 1'b1}, {8'h8B, 1'b1, 1'b1}, {8'h01, 1'b0, 1'b0},
    {8'h0F, 1'b1, 1'b0}, {8'h04, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic pad_i = 1'b0, cfg_we = 1'b0, cfg_reg_i = 1'b0, cfg_pol_i = 1'b0;
  logic [MASK_W-1:0] cfg_true_i = '0, cfg_comp_i = '0;
  logic pad_o, pad_oe_o;
  int checks = 0, fails = 0;
  logic prev;

  always #10 clk = ~clk;

  pal_macrocell #(.N_IN(N_IN), .N_SUM(N_SUM)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .pad_i(pad_i), .cfg_we(cfg_we),
    .cfg_true_i(cfg_true_i), .cfg_comp_i(cfg_comp_i), .cfg_reg_i(cfg_reg_i),
    .cfg_pol_i(cfg_pol_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // every term disabled: true and complement of input 0 both connected
  task automatic clear_masks();
    cfg_true_i = '0;
    cfg_comp_i = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      cfg_true_i[k*IN_W] = 1'b1;
      cfg_comp_i[k*IN_W] = 1'b1;
    end
  endtask

  task automatic set_term(input int k, input logic [IN_W-1:0] t,
                          input logic [IN_W-1:0] c);
    cfg_true_i[k*IN_W +: IN_W] = t;
    cfg_comp_i[k*IN_W +: IN_W] = c;
  endtask

  task automatic load(input logic rmode, input logic pol);
    @(negedge clk);
    cfg_reg_i = rmode;
    cfg_pol_i = pol;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #35;
    chk("R10 reset pad_o", pad_o, 1'b0);
    chk("R10 reset pad_oe", pad_oe_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    in_i = 8'hFF;
    #5;
    chk("R10 unprogrammed pad_o", pad_o, 1'b0);
    chk("R10 unprogrammed pad_oe", pad_oe_o, 1'b0);

    // config A: t0 = in0&in1, t1 = ~in2&in3, oe = in7
    clear_masks();
    set_term(0, 9'h003, 9'h000);
    set_term(1, 9'h008, 9'h004);
    set_term(N_SUM, 9'h080, 9'h000);
    load(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_i = VEC[i][9:2];
      #5;
      chk("R1 R2 table pad_o", pad_o, VEC[i][1]);
      chk("R7 table pad_oe", pad_oe_o, VEC[i][0]);
    end

    // R6 polarity in combinational mode
    load(1'b0, 1'b1);
    @(negedge clk); in_i = 8'h03; #5;
    chk("R6 inverted high sum", pad_o, 1'b0);
    @(negedge clk); in_i = 8'h0C; #5;
    chk("R6 inverted low sum", pad_o, 1'b1);

    // R9 no write strobe: config inputs ignored
    cfg_pol_i = 1'b0;
    cfg_reg_i = 1'b1;
    @(negedge clk); in_i = 8'h03;
    @(negedge clk); #5;
    chk("R9 ignored without strobe", pad_o, 1'b0);

    // config B: registered, t0 = in0, preset = in4, clear = in5
    clear_masks();
    set_term(0, 9'h001, 9'h000);
    set_term(N_SUM + 1, 9'h010, 9'h000);
    set_term(N_SUM + 2, 9'h020, 9'h000);
    in_i = 8'h00;
    load(1'b1, 1'b0);
    @(negedge clk); in_i = 8'h00;
    @(negedge clk); in_i = 8'h01; #5;
    chk("R3 holds before edge", pad_o, 1'b0);
    @(negedge clk); #5;
    chk("R3 captured after edge", pad_o, 1'b1);
    in_i = 8'h00;
    @(negedge clk); #5;
    chk("R3 captured low", pad_o, 1'b0);
    in_i = 8'h10;
    @(negedge clk); #5;
    chk("R4 preset sets", pad_o, 1'b1);
    in_i = 8'h20; #3;
    chk("R5 async clear", pad_o, 1'b0);
    in_i = 8'h30;
    @(negedge clk); #5;
    chk("R5 clear beats preset", pad_o, 1'b0);

    // config C: registered toggle, t0 = ~feedback
    clear_masks();
    set_term(0, 9'h000, 9'h100);
    in_i = 8'h00;
    load(1'b1, 1'b0);
    pad_i = 1'b1;
    @(negedge clk); #5; prev = pad_o;
    @(negedge clk); #5;
    chk("R8 registered feedback toggle", pad_o, ~prev);
    prev = pad_o; pad_i = 1'b0;
    @(negedge clk); #5;
    chk("R8 toggle ignores pad_i", pad_o, ~prev);

    // config D: combinational, t0 = pad feedback
    clear_masks();
    set_term(0, 9'h100, 9'h000);
    load(1'b0, 1'b0);
    @(negedge clk); pad_i = 1'b1; #5;
    chk("R8 comb feedback high", pad_o, 1'b1);
    pad_i = 1'b0; #3;
    chk("R8 comb feedback low", pad_o, 1'b0);

    // R10 reset returns to unprogrammed state
    rst_n = 1'b0; #3;
    chk("R10 reset after use", pad_oe_o, 1'b0);
    pad_i = 1'b1; #3;
    chk("R10 reset clears config", pad_o, 1'b0);
    summary();
  end

endmodule